// File: doc/BRIEF.md
# Masked Pattern Match Trigger Unit

This block watches a stream of 256-bit data samples. It tests each valid sample against two independent programmable patterns. The first pattern decides which samples are worth capturing. The second raises a trigger. Each pattern has a 256-bit value and a 256-bit mask. Only data bits whose mask bit is 1 take part in the comparison.

A shared mode bit selects how the patterns are applied:
- In value mode, a masked bit matches when it equals its pattern bit.
- In toggle mode, a masked bit matches when "changed since the previous valid sample" equals its pattern bit. A bit with pattern 1 must change, and a bit with pattern 0 must hold.

Two enable bits decide whether a capture match or a trigger match also asks the downstream timestamp logic for a timestamp. All settings are loaded through a word-addressed register port that reads back in the same cycle. Every match output is a registered pulse. It appears in the cycle after the sample edge and lasts one cycle for each matching valid sample.

Top module: `pattern_trigger_unit`

## Requirements
- R1: After reset every output is low, and every pattern word and the control word read back as zero.
- R2: The register port maps 32-bit words as follows:
  - addresses 0x00-0x07: capture value words
  - addresses 0x08-0x0F: capture mask words
  - addresses 0x10-0x17: trigger value words
  - addresses 0x18-0x1F: trigger mask words
  - address 0x20: the control word

  Word k covers data bits 32k+31 down to 32k. A word written with reg_we high at a clock edge reads back on reg_rdata, which follows reg_addr in the same cycle.
- R3: In value mode (control bit 0 = 0), a set matches when every data bit whose mask bit is 1 equals its value bit. Bits with mask 0 are ignored.
- R4: A set whose mask is all zero never matches.
- R5: In toggle mode (control bit 0 = 1), both sets compare the XOR of the current sample with the previous valid sample against their value words, under their masks. The previous sample is zero after reset, and it is updated only by valid samples.
- R6: capture_ts_req pulses together with capture_hit only when control bit 1 is 1.
- R7: trigger_ts_req pulses together with trigger_hit only when control bit 2 is 1.
- R8: Control bit 3 (trigger type) reads back as written and has no effect on any output.
- R9: The outputs are registered. They rise in the cycle after a valid sample edge and are low in any cycle after an edge where sample_valid was low.
- R10: The capture and trigger sets are evaluated independently, each from its own value and mask words.
- R11: Writes to addresses 0x21-0x3F are ignored, and reads from those addresses return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, available in the same cycle |
| sample_valid | input | 1 | sample_data holds a sample to evaluate |
| sample_data | input | 256 | Sampled data set |
| capture_hit | output | 1 | Capture pattern matched |
| trigger_hit | output | 1 | Trigger pattern matched |
| capture_ts_req | output | 1 | Timestamp request for a capture match |
| trigger_ts_req | output | 1 | Timestamp request for a trigger match |

## Verification
The assertions check several rules on every cycle:
- a timestamp request never occurs without its match pulse;
- no pulse follows an edge without a valid sample;
- an all-zero mask never produces a hit;
- a disabled timestamp enable keeps its request low.

The bench scenarios are needed for the rest. They show whether a masked comparison gives the right answer for particular data, how toggle detection depends on the stored previous sample and on invalid cycles, that the two sets are independent, and that the register map reads back correctly.

// File: rtl/mpm_pkg.sv
package mpm_pkg;
  localparam int WORD_W    = 32;
  localparam int NUM_WORDS = 8;
  localparam int DATA_W    = WORD_W * NUM_WORDS;
  localparam int ADDR_W    = 6;
  localparam int CTRL_W    = 4;
  localparam int NUM_SETS  = 2;
  localparam int SET_CAP   = 0;
  localparam int SET_TRG   = 1;
endpackage

// File: rtl/mpm_regfile.sv
module mpm_regfile #(
  parameter int WORD_W    = mpm_pkg::WORD_W,
  parameter int NUM_WORDS = mpm_pkg::NUM_WORDS,
  parameter int ADDR_W    = mpm_pkg::ADDR_W,
  parameter int CTRL_W    = mpm_pkg::CTRL_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [WORD_W-1:0]           wdata,
  output logic [WORD_W-1:0]           rdata,
  output logic [WORD_W*NUM_WORDS-1:0] cap_val,
  output logic [WORD_W*NUM_WORDS-1:0] cap_mask,
  output logic [WORD_W*NUM_WORDS-1:0] trg_val,
  output logic [WORD_W*NUM_WORDS-1:0] trg_mask,
  output logic [CTRL_W-1:0]           ctrl
);
  localparam int TOTAL = 4 * NUM_WORDS;
  localparam int IDX_W = $clog2(TOTAL);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(TOTAL);

  logic [WORD_W-1:0] word_q [TOTAL];
  logic [TOTAL-1:0]  word_we;
  logic              ctrl_we;
  logic [CTRL_W-1:0] ctrl_q;

  // Write decode
  always_comb begin
    word_we = '0;
    if (wr_en && addr < CTRL_A) word_we[addr[IDX_W-1:0]] = 1'b1;
    ctrl_we = wr_en && (addr == CTRL_A);
  end

  for (genvar i = 0; i < TOTAL; i++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          word_q[i] <= '0;
      else if (word_we[i]) word_q[i] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_we) ctrl_q <= wdata[CTRL_W-1:0];
  end

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_flat
    assign cap_val [w*WORD_W +: WORD_W] = word_q[w];
    assign cap_mask[w*WORD_W +: WORD_W] = word_q[NUM_WORDS + w];
    assign trg_val [w*WORD_W +: WORD_W] = word_q[2*NUM_WORDS + w];
    assign trg_mask[w*WORD_W +: WORD_W] = word_q[3*NUM_WORDS + w];
  end

  assign ctrl = ctrl_q;

  // Same-cycle read mux
  always_comb begin
    rdata = '0;
    if (addr < CTRL_A)       rdata = word_q[addr[IDX_W-1:0]];
    else if (addr == CTRL_A) rdata[CTRL_W-1:0] = ctrl_q;
  end
endmodule

// File: rtl/mpm_matcher.sv
module mpm_matcher #(
  parameter int DATA_W = mpm_pkg::DATA_W
) (
  input  logic [DATA_W-1:0] cur,
  input  logic [DATA_W-1:0] prev,
  input  logic [DATA_W-1:0] pat_val,
  input  logic [DATA_W-1:0] pat_mask,
  input  logic              toggle_mode,
  output logic              hit
);
  logic [DATA_W-1:0] operand;
  logic [DATA_W-1:0] miss;

  always_comb begin
    operand = toggle_mode ? (cur ^ prev) : cur;
    miss    = (operand ^ pat_val) & pat_mask;
    hit     = (|pat_mask) && !(|miss);
  end
endmodule

// File: rtl/pattern_trigger_unit.sv
module pattern_trigger_unit #(
  parameter int WORD_W    = mpm_pkg::WORD_W,
  parameter int NUM_WORDS = mpm_pkg::NUM_WORDS,
  parameter int ADDR_W    = mpm_pkg::ADDR_W,
  parameter int DATA_W    = WORD_W * NUM_WORDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  input  logic              sample_valid,
  input  logic [DATA_W-1:0] sample_data,
  output logic              capture_hit,
  output logic              trigger_hit,
  output logic              capture_ts_req,
  output logic              trigger_ts_req
);
  import mpm_pkg::*;

  logic [DATA_W-1:0] cap_val_w, cap_mask_w, trg_val_w, trg_mask_w;
  logic [CTRL_W-1:0] ctrl_w;
  logic              toggle_w, cap_ts_en_w, trg_ts_en_w;

  mpm_regfile #(
    .WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .ADDR_W(ADDR_W), .CTRL_W(CTRL_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata),
    .cap_val(cap_val_w), .cap_mask(cap_mask_w),
    .trg_val(trg_val_w), .trg_mask(trg_mask_w), .ctrl(ctrl_w)
  );

  // Control bits: [0] toggle mode, [1] capture ts, [2] trigger ts, [3] trigger type (stored only)
  assign toggle_w    = ctrl_w[0];
  assign cap_ts_en_w = ctrl_w[1];
  assign trg_ts_en_w = ctrl_w[2];

  // Previous valid sample
  logic [DATA_W-1:0] prev_q, prev_d;
  always_comb prev_d = sample_valid ? sample_data : prev_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_d;
  end

  logic [DATA_W-1:0]   set_val  [NUM_SETS];
  logic [DATA_W-1:0]   set_mask [NUM_SETS];
  logic [NUM_SETS-1:0] set_ts_en, set_hit;
  logic [NUM_SETS-1:0] hit_d, hit_q, ts_d, ts_q;

  assign set_val[SET_CAP]   = cap_val_w;
  assign set_mask[SET_CAP]  = cap_mask_w;
  assign set_ts_en[SET_CAP] = cap_ts_en_w;
  assign set_val[SET_TRG]   = trg_val_w;
  assign set_mask[SET_TRG]  = trg_mask_w;
  assign set_ts_en[SET_TRG] = trg_ts_en_w;

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    mpm_matcher #(.DATA_W(DATA_W)) u_match (
      .cur(sample_data), .prev(prev_q),
      .pat_val(set_val[s]), .pat_mask(set_mask[s]),
      .toggle_mode(toggle_w), .hit(set_hit[s])
    );
  end

  always_comb begin
    hit_d = set_hit & {NUM_SETS{sample_valid}};
    ts_d  = hit_d & set_ts_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q <= '0;
      ts_q  <= '0;
    end else begin
      hit_q <= hit_d;
      ts_q  <= ts_d;
    end
  end

  assign capture_hit    = hit_q[SET_CAP];
  assign trigger_hit    = hit_q[SET_TRG];
  assign capture_ts_req = ts_q[SET_CAP];
  assign trigger_ts_req = ts_q[SET_TRG];
endmodule

// File: rtl/pattern_trigger_unit_chk.sv
module pattern_trigger_unit_chk #(
  parameter int DATA_W = mpm_pkg::DATA_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sample_valid,
  input logic              capture_hit,
  input logic              trigger_hit,
  input logic              capture_ts_req,
  input logic              trigger_ts_req,
  input logic [DATA_W-1:0] cap_mask,
  input logic [DATA_W-1:0] trg_mask,
  input logic              cap_ts_en,
  input logic              trg_ts_en
);
  p_cap_ts_with_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    capture_ts_req |-> capture_hit);

  p_trg_ts_with_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    trigger_ts_req |-> trigger_hit);

  p_no_pulse_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(sample_valid) |-> (!capture_hit && !trigger_hit));

  p_cap_zero_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cap_mask == '0) |-> !capture_hit);

  p_trg_zero_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(trg_mask == '0) |-> !trigger_hit);

  p_cap_ts_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!cap_ts_en) |-> !capture_ts_req);

  p_trg_ts_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!trg_ts_en) |-> !trigger_ts_req);
endmodule

bind pattern_trigger_unit pattern_trigger_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid),
  .capture_hit(capture_hit), .trigger_hit(trigger_hit),
  .capture_ts_req(capture_ts_req), .trigger_ts_req(trigger_ts_req),
  .cap_mask(cap_mask_w), .trg_mask(trg_mask_w),
  .cap_ts_en(cap_ts_en_w), .trg_ts_en(trg_ts_en_w)
);

// File: tb/pattern_trigger_unit_bench.sv
`timescale 1ns/1ps
module pattern_trigger_unit_bench;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         reg_we;
  logic [5:0]   reg_addr;
  logic [31:0]  reg_wdata;
  logic [31:0]  reg_rdata;
  logic         sample_valid;
  logic [255:0] sample_data;
  logic         capture_hit, trigger_hit, capture_ts_req, trigger_ts_req;

  int n_run  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  pattern_trigger_unit u_pattern_trigger_unit (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sample_valid(sample_valid), .sample_data(sample_data),
    .capture_hit(capture_hit), .trigger_hit(trigger_hit),
    .capture_ts_req(capture_ts_req), .trigger_ts_req(trigger_ts_req)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] outs();
    return {trigger_ts_req, capture_ts_req, trigger_hit, capture_hit};
  endfunction

  // Word 0 and word 7 carry the masked bits; the middle words are filler
  function automatic logic [255:0] mk(input logic [31:0] w0, input logic [31:0] w7);
    logic [255:0] d;
    d = {8{32'hDEADBEEF}};
    d[31:0]    = w0;
    d[255:224] = w7;
    return d;
  endfunction

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [5:0] a, input logic [31:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  // Outputs are expected in {trg_ts, cap_ts, trg_hit, cap_hit} order
  task automatic send(input string tag, input logic [255:0] d, input bit do_chk, input logic [3:0] exp);
    @(negedge clk);
    sample_data = d; sample_valid = 1'b1;
    @(posedge clk); #1;
    if (do_chk) chk(tag, 32'(outs()), 32'(exp));
    @(negedge clk);
    sample_valid = 1'b0;
    @(posedge clk); #1;
    if (do_chk) chk({"R9 single pulse after ", tag}, 32'(outs()), 32'h0);
  endtask

  task automatic t_reset();
    chk("R1 outputs after reset", 32'(outs()), 32'h0);
    rd_chk("R1 capture value word 0", 6'h00, 32'h0);
    rd_chk("R1 trigger mask word 7", 6'h1F, 32'h0);
    rd_chk("R1 control word", 6'h20, 32'h0);
  endtask

  task automatic t_unmapped();
    wr(6'h2A, 32'hFFFF_FFFF);
    rd_chk("R11 unmapped read", 6'h2A, 32'h0);
    rd_chk("R11 capture word 0 untouched", 6'h00, 32'h0);
    rd_chk("R11 control untouched", 6'h20, 32'h0);
  endtask

  task automatic t_readback();
    wr(6'h03, 32'hA5A5_5A5A);
    wr(6'h1F, 32'h1234_5678);
    wr(6'h20, 32'h0000_000F);
    rd_chk("R2 capture value word 3", 6'h03, 32'hA5A5_5A5A);
    rd_chk("R2 trigger mask word 7", 6'h1F, 32'h1234_5678);
    rd_chk("R8 control incl trigger type", 6'h20, 32'h0000_000F);
    wr(6'h03, 32'h0);
    wr(6'h1F, 32'h0);
    wr(6'h20, 32'h0);
    rd_chk("R2 control cleared", 6'h20, 32'h0);
  endtask

  task automatic t_zero_mask();
    send("R4 zero masks, zero data", '0, 1'b1, 4'b0000);
  endtask

  task automatic t_value();
    wr(6'h08, 32'h0000_FFFF);
    wr(6'h00, 32'h0000_1234);
    send("R3 masked value match", mk(32'hFFFF_1234, 32'h0), 1'b1, 4'b0001);
    send("R3 masked value miss", mk(32'h0000_1235, 32'h0), 1'b1, 4'b0000);
  endtask

  task automatic t_trigger();
    wr(6'h1F, 32'hFF00_0000);
    wr(6'h17, 32'hAB00_0000);
    send("R10 trigger only", mk(32'h0, 32'hAB12_3456), 1'b1, 4'b0010);
    send("R10 both sets", mk(32'h1234, 32'hAB00_0000), 1'b1, 4'b0011);
    send("R10 capture only", mk(32'h1234, 32'hAC00_0000), 1'b1, 4'b0001);
  endtask

  task automatic t_timestamp();
    wr(6'h20, 32'h2);
    send("R6 capture ts enabled", mk(32'h1234, 32'hAB00_0000), 1'b1, 4'b0111);
    wr(6'h20, 32'hC);
    send("R7 trigger ts with type 1", mk(32'h1234, 32'hAB00_0000), 1'b1, 4'b1011);
    wr(6'h20, 32'h4);
    send("R8 trigger type 0 same result", mk(32'h1234, 32'hAB00_0000), 1'b1, 4'b1011);
  endtask

  task automatic t_toggle();
    wr(6'h20, 32'h1);
    wr(6'h08, 32'h0000_0003);
    wr(6'h00, 32'h0000_0001);
    send("R5 prime", mk(32'h0, 32'h0), 1'b0, 4'b0000);
    send("R5 bit0 toggles", mk(32'h1, 32'h0), 1'b1, 4'b0001);
    send("R5 no toggle", mk(32'h1, 32'h0), 1'b1, 4'b0000);
    send("R5 forbidden bit1 toggles", mk(32'h2, 32'h0), 1'b1, 4'b0000);
    send("R5 bit0 toggles bit1 holds", mk(32'h3, 32'h0), 1'b1, 4'b0001);
    // Invalid cycle with different data must not disturb the previous sample
    @(negedge clk);
    sample_data = mk(32'h0, 32'h0); sample_valid = 1'b0;
    @(posedge clk); #1;
    chk("R9 no pulse when not valid", 32'(outs()), 32'h0);
    send("R5 previous kept across invalid cycle", mk(32'h2, 32'h0), 1'b1, 4'b0001);
    send("R5 trigger toggle set", mk(32'h2, 32'hAB00_0000), 1'b1, 4'b0010);
  endtask

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    sample_valid = 1'b0; sample_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_unmapped();
    t_readback();
    t_zero_mask();
    t_value();
    t_trigger();
    t_timestamp();
    t_toggle();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule